// File: doc/BRIEF.md
# 3x3 Gaussian Smoothing Datapath

This block takes one complete 3x3 window of pixels per cycle and returns a smoothed pixel. The kernel is 1-2-1 / 2-4-2 / 1-2-1, so the weights sum to 16. Each pixel is scaled by its weight with a fixed left shift, and no multiplier is used. The nine scaled terms go into a carry-save reduction tree that has three levels. The first level is made of three 3:2 carry-save adders. The next two levels are 4:2 compressors, each built from multiplexer cells. What leaves the tree is a pair of vectors. These are registered, then summed by one carry-propagate adder. The result is divided by 16 by keeping only its upper bits.

An upstream window generator drives the nine pixels and a strobe. The block returns the smoothed value and its own strobe exactly two cycles later. Line storage, window formation and image-border policy are the job of the surrounding logic.

Top module: `gauss3x3_filter`

## Requirements
- R1: Pixel k of the window (k = 3*row + col, row and col 0..2) sits at win_pix bits [k*PIX_W +: PIX_W]. The weights are 1 for k = 0, 2, 6, 8, 2 for k = 1, 3, 5, 7, and 4 for k = 4. A window with only pixel k non-zero at value p gives floor(p*weight/16).
- R2: Each output equals floor(S/16), where S is the weighted sum of the nine pixels. The remainder is truncated and never rounded. The final adder forms S exactly in PIX_W+4 bits.
- R3: A window whose nine pixels are all at full scale (2^PIX_W - 1) gives a full-scale output. Nothing wraps.
- R4: out_valid follows in_valid delayed by exactly two clock cycles. This holds for isolated strobes and for strobes on every cycle, and each strobe yields the result of its own window.
- R5: In a cycle where out_valid is not asserted, out_pix keeps the last produced result. Window contents presented while in_valid is low change nothing.
- R6: While rst_n is low, out_valid and out_pix are 0. rst_n takes effect asynchronously, and its release reaches the registers two clock edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Marks win_pix as a window to be filtered this cycle |
| win_pix | input | 9*PIX_W | Nine window pixels, pixel k at bits [k*PIX_W +: PIX_W] |
| out_valid | output | 1 | Marks out_pix as a new result |
| out_pix | output | PIX_W | Smoothed pixel, weighted sum divided by 16 |

## Verification
The bench builds two instances: one with PIX_W = 4 and one at the default PIX_W = 8, and drives both with the same strobe. At four bits, every value of every window position can be swept against several background levels in a few hundred cycles. That sweep reaches every truncation remainder and every full-scale carry pattern through the compressor cells. The 8-bit instance repeats the sweep with scaled values and checks the 255 window, so the default width sees the same corners.

// File: rtl/gauss3_pkg.sv
package gauss3_pkg;

  // taps in one 3x3 window
  localparam int unsigned TAPS      = 9;
  // log2 of the kernel weight total (1+2+1+2+4+2+1+2+1 = 16)
  localparam int unsigned GAIN_LOG2 = 4;

  // Left-shift amount that applies the kernel weight of tap k.
  // One bit per axis for which the tap lies on the middle line.
  function automatic int unsigned tap_shift(input int unsigned k);
    int unsigned sh;
    sh = 0;
    if ((k / 3) == 1) sh = sh + 1;
    if ((k % 3) == 1) sh = sh + 1;
    return sh;
  endfunction

endpackage

// File: rtl/gauss3_csa.sv
// 3:2 carry-save adder across a W-bit word. The carry output is pre-shifted.
// The carry out of the top bit is dropped, which is safe while the true
// total fits in W bits.
module gauss3_csa #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] s,
  output logic [W-1:0] cy
);

  logic [W-2:0] maj;

  assign s = a ^ b ^ c;

  for (genvar i = 0; i < W - 1; i++) begin : g_maj
    assign maj[i] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
  end

  assign cy = {maj, 1'b0};

endmodule

// File: rtl/gauss3_c42.sv
// 4:2 compressor across a W-bit word, made of two multiplexers per bit plus
// XOR parity. The lateral carry goes from bit i to bit i+1. The output carry
// is pre-shifted. Carries past bit W-1 are dropped (the total fits in W bits).
module gauss3_c42 #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] x1,
  input  logic [W-1:0] x2,
  input  logic [W-1:0] x3,
  input  logic [W-1:0] x4,
  output logic [W-1:0] s,
  output logic [W-1:0] cy
);

  logic [W-1:0] par;
  logic [W-1:0] lat_in;
  logic [W-2:0] lat_out;
  logic [W-2:0] hi;

  assign par    = x1 ^ x2 ^ x3 ^ x4;
  assign lat_in = {lat_out, 1'b0};

  for (genvar i = 0; i < W - 1; i++) begin : g_cell
    // first mux: majority of x1..x3 selected by x1^x2
    assign lat_out[i] = (x1[i] ^ x2[i]) ? x3[i] : x1[i];
    // second mux: majority of (x1^x2^x3, x4, lateral in) selected by parity
    assign hi[i]      = par[i] ? lat_in[i] : x4[i];
  end

  assign s  = par ^ lat_in;
  assign cy = {hi, 1'b0};

endmodule

// File: rtl/gauss3_tree.sv
// Three-level reduction of nine addends down to two vectors.
//   level 1: three 3:2 adders, 9 -> 6
//   level 2: one 4:2 compressor on four of the six, 6 -> 4
//   level 3: one 4:2 compressor, 4 -> 2
module gauss3_tree import gauss3_pkg::*; #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] addend [TAPS],
  output logic [W-1:0] vec_s,
  output logic [W-1:0] vec_c
);

  localparam int unsigned GROUPS = TAPS / 3;

  logic [W-1:0] l1_s [GROUPS];
  logic [W-1:0] l1_c [GROUPS];
  logic [W-1:0] l2_s;
  logic [W-1:0] l2_c;

  for (genvar g = 0; g < GROUPS; g++) begin : g_l1
    gauss3_csa #(.W(W)) u_csa (
      .a  (addend[3*g]),
      .b  (addend[3*g+1]),
      .c  (addend[3*g+2]),
      .s  (l1_s[g]),
      .cy (l1_c[g])
    );
  end

  gauss3_c42 #(.W(W)) u_l2 (
    .x1 (l1_s[0]),
    .x2 (l1_c[0]),
    .x3 (l1_s[1]),
    .x4 (l1_c[1]),
    .s  (l2_s),
    .cy (l2_c)
  );

  gauss3_c42 #(.W(W)) u_l3 (
    .x1 (l2_s),
    .x2 (l2_c),
    .x3 (l1_s[2]),
    .x4 (l1_c[2]),
    .s  (vec_s),
    .cy (vec_c)
  );

endmodule

// File: rtl/gauss3x3_filter.sv
module gauss3x3_filter import gauss3_pkg::*; #(
  parameter int unsigned PIX_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [TAPS*PIX_W-1:0]   win_pix,
  output logic                    out_valid,
  output logic [PIX_W-1:0]        out_pix
);

  localparam int unsigned SUM_W = PIX_W + GAIN_LOG2;

  // reset release synchronizer
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_core_n = rst_sync_q[1];

  // weighting by shift
  logic [SUM_W-1:0] addend [TAPS];

  for (genvar k = 0; k < TAPS; k++) begin : g_weight
    assign addend[k] = {{GAIN_LOG2{1'b0}}, win_pix[k*PIX_W +: PIX_W]} << tap_shift(k);
  end

  // compression tree
  logic [SUM_W-1:0] tree_s;
  logic [SUM_W-1:0] tree_c;

  gauss3_tree #(.W(SUM_W)) u_tree (
    .addend (addend),
    .vec_s  (tree_s),
    .vec_c  (tree_c)
  );

  // pipeline state
  logic             st1_v_q, st1_v_d;
  logic [SUM_W-1:0] st1_s_q, st1_s_d;
  logic [SUM_W-1:0] st1_c_q, st1_c_d;
  logic             st2_v_q, st2_v_d;
  logic [PIX_W-1:0] pix_q,   pix_d;
  logic [SUM_W-1:0] fin_sum;

  // next state
  always_comb begin
    st1_v_d = in_valid;
    st1_s_d = st1_s_q;
    st1_c_d = st1_c_q;
    if (in_valid) begin
      st1_s_d = tree_s;
      st1_c_d = tree_c;
    end

    fin_sum = st1_s_q + st1_c_q;

    st2_v_d = st1_v_q;
    pix_d   = pix_q;
    if (st1_v_q) begin
      pix_d = fin_sum[SUM_W-1 -: PIX_W];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st1_v_q <= 1'b0;
      st1_s_q <= '0;
      st1_c_q <= '0;
      st2_v_q <= 1'b0;
      pix_q   <= '0;
    end else begin
      st1_v_q <= st1_v_d;
      st1_s_q <= st1_s_d;
      st1_c_q <= st1_c_d;
      st2_v_q <= st2_v_d;
      pix_q   <= pix_d;
    end
  end

  assign out_valid = st2_v_q;
  assign out_pix   = pix_q;

endmodule

// File: rtl/gauss3x3_filter_chk.sv
module gauss3x3_filter_chk import gauss3_pkg::*; #(
  parameter int unsigned PIX_W = 8
) (
  input logic                  clk,
  input logic                  rst_core_n,
  input logic                  in_valid,
  input logic [TAPS*PIX_W-1:0] win_pix,
  input logic [PIX_W+GAIN_LOG2-1:0] fin_sum,
  input logic                  out_valid,
  input logic [PIX_W-1:0]      out_pix
);

  localparam int unsigned SUM_W = PIX_W + GAIN_LOG2;

  logic [SUM_W-1:0] ref_sum;

  always_comb begin
    ref_sum = '0;
    for (int k = 0; k < TAPS; k++) begin
      ref_sum = ref_sum + ({{GAIN_LOG2{1'b0}}, win_pix[k*PIX_W +: PIX_W]} << tap_shift(k));
    end
  end

  // R2: the final adder yields the exact weighted sum of the window one cycle earlier
  a_r2_exact_sum: assert property (@(posedge clk) disable iff (!rst_core_n)
    in_valid |=> (fin_sum == $past(ref_sum)));

  // R3: a full-scale window gives a full-scale result
  a_r3_full_scale: assert property (@(posedge clk) disable iff (!rst_core_n)
    (in_valid && (&win_pix)) |=> ##1 (&out_pix));

  // R4: a strobe comes out two cycles later
  a_r4_strobe_out: assert property (@(posedge clk) disable iff (!rst_core_n)
    in_valid |=> ##1 out_valid);

  // R4: no strobe in means no strobe out two cycles later
  a_r4_quiet_out: assert property (@(posedge clk) disable iff (!rst_core_n)
    !in_valid |=> ##1 !out_valid);

  // R5: the output value holds when no result is issued
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    !in_valid |=> ##1 $stable(out_pix));

endmodule

bind gauss3x3_filter gauss3x3_filter_chk #(.PIX_W(PIX_W)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .in_valid   (in_valid),
  .win_pix    (win_pix),
  .fin_sum    (fin_sum),
  .out_valid  (out_valid),
  .out_pix    (out_pix)
);

// File: tb/tb_gauss3x3_filter.sv
module tb_gauss3x3_filter;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [35:0] win4;
  logic [71:0] win8;
  logic        ov4, ov8;
  logic [3:0]  op4;
  logic [7:0]  op8;

  int tests;
  int fails;
  bit done;

  gauss3x3_filter #(.PIX_W(4)) dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .win_pix (win4),
    .out_valid (ov4), .out_pix (op4)
  );

  gauss3x3_filter #(.PIX_W(8)) dut_w8 (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .win_pix (win8),
    .out_valid (ov8), .out_pix (op8)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  // expected pipeline: slot 1 = last step, slot 2 = two steps ago
  bit    ev1, ev2;
  int    e4_1, e4_2, e8_1, e8_2;
  string t1, t2;
  int    last4, last8;

  function automatic int kern_w(input int k);
    if (k == 4) return 4;
    if ((k % 2) == 1) return 2;
    return 1;
  endfunction

  function automatic int gexp(input logic [71:0] w, input int pw);
    int s;
    s = 0;
    for (int k = 0; k < 9; k++) begin
      int p;
      p = 0;
      for (int b = 0; b < pw; b++) p = p | (int'(w[k*pw+b]) << b);
      s = s + p * kern_w(k);
    end
    return s / 16;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // one cycle: check the result of the window driven two steps ago, then drive
  task automatic step(input bit v, input logic [35:0] w4, input logic [71:0] w8,
                      input string tag);
    @(negedge clk);
    chk(ov4 == ev2, t2, "valid w4", int'(ov4), int'(ev2));
    chk(ov8 == ev2, t2, "valid w8", int'(ov8), int'(ev2));
    if (ev2) begin
      chk(int'(op4) == e4_2, t2, "pix w4", int'(op4), e4_2);
      chk(int'(op8) == e8_2, t2, "pix w8", int'(op8), e8_2);
      last4 = e4_2;
      last8 = e8_2;
    end else begin
      chk(int'(op4) == last4, "R5", "hold w4", int'(op4), last4);
      chk(int'(op8) == last8, "R5", "hold w8", int'(op8), last8);
    end
    ev2  = ev1;  e4_2 = e4_1;  e8_2 = e8_1;  t2 = t1;
    ev1  = v;    e4_1 = gexp({36'd0, w4}, 4);  e8_1 = gexp(w8, 8);  t1 = tag;
    in_valid = v;
    win4     = w4;
    win8     = w8;
  endtask

  function automatic logic [35:0] fill4(input int bg, input int k, input int v);
    logic [35:0] w;
    for (int i = 0; i < 9; i++) w[i*4 +: 4] = 4'((i == k) ? v : bg);
    return w;
  endfunction

  function automatic logic [71:0] fill8(input int bg, input int k, input int v);
    logic [71:0] w;
    for (int i = 0; i < 9; i++) w[i*8 +: 8] = 8'((i == k) ? v : bg);
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R4 watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    tests = 0; fails = 0; done = 1'b0;
    ev1 = 0; ev2 = 0; e4_1 = 0; e4_2 = 0; e8_1 = 0; e8_2 = 0;
    t1 = "R4"; t2 = "R4"; last4 = 0; last8 = 0;
    in_valid = 1'b0; win4 = '1; win8 = '1;
    rst_n = 1'b0;

    // R6: reset state, even with a full-scale window presented
    repeat (3) @(negedge clk);
    chk(ov4 == 1'b0 && ov8 == 1'b0, "R6", "reset valid", int'(ov4 | ov8), 0);
    chk(op4 == 4'd0, "R6", "reset pix w4", int'(op4), 0);
    chk(op8 == 8'd0, "R6", "reset pix w8", int'(op8), 0);
    rst_n = 1'b1;
    win4 = '0; win8 = '0;

    // settle through the reset synchronizer; outputs stay at reset values (R6)
    for (int i = 0; i < 4; i++) step(1'b0, 36'd0, 72'd0, "R6");

    // R1: single-tap impulses, full scale, every position
    for (int k = 0; k < 9; k++) step(1'b1, fill4(0, k, 15), fill8(0, k, 255), "R1");
    for (int k = 0; k < 9; k++) step(1'b1, fill4(0, k, 9), fill8(0, k, 201), "R1");

    // R2: sweep every value at every position over several backgrounds
    for (int bgi = 0; bgi < 4; bgi++) begin
      for (int k = 0; k < 9; k++) begin
        for (int v = 0; v < 16; v++) begin
          step(1'b1, fill4(bgi * 5, k, v), fill8(bgi * 85, k, v * 17 + bgi), "R2");
        end
      end
    end

    // R3: full scale and near full scale
    step(1'b1, fill4(15, 0, 15), fill8(255, 0, 255), "R3");
    step(1'b1, fill4(15, 4, 14), fill8(255, 4, 254), "R3");
    step(1'b1, fill4(15, 0, 15), fill8(255, 0, 255), "R3");
    step(1'b0, 36'd0, 72'd0, "R3");

    // R4: strobe on every cycle with random windows
    for (int n = 0; n < 500; n++) begin
      logic [35:0] w4;
      logic [71:0] w8;
      for (int i = 0; i < 9; i++) begin
        w4[i*4 +: 4] = 4'($urandom);
        w8[i*8 +: 8] = 8'($urandom);
      end
      step(1'b1, w4, w8, "R4");
    end

    // R5: sparse strobes, random contents on idle cycles must not leak out
    for (int n = 0; n < 400; n++) begin
      logic [35:0] w4;
      logic [71:0] w8;
      for (int i = 0; i < 9; i++) begin
        w4[i*4 +: 4] = 4'($urandom);
        w8[i*8 +: 8] = 8'($urandom);
      end
      step(($urandom % 3) == 0, w4, w8, "R5");
    end

    for (int i = 0; i < 3; i++) step(1'b0, '1, '1, "R5");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule